// File: doc/BRIEF.md
# MDIO Management Master (Clause 22 and Clause 45)

This block is a register-mapped master for the two-wire PHY management bus. Software writes a small set of registers, and the block sends one serial frame for each command on the management clock and data line. The data line is carried as three signals: a driven value, an output enable and a sampled input. A configuration bit selects one of two frame formats. The first format carries a 5-bit PHY address and a 5-bit register number in a single frame. The second format first sends a separate address frame that carries a 16-bit register address, and then sends a write frame or a read frame.

Each frame is 64 bit times long. It starts with 32 bits of ones. These are followed by a 2-bit start code, a 2-bit opcode, the port address, the device field, two turnaround bits and 16 data bits. The master changes the data line only after a falling edge of the management clock and samples it on the rising edge. In a read, the master releases the line from the first turnaround bit to the end of the frame. If the PHY leaves the second turnaround bit high, the block records a sticky read error. The management clock is the system clock divided by a programmable value. A divider of zero holds the clock low and the frame waits until a nonzero divider is written.

Register select (`reg_sel`) values: 0 is status/config, 1 is control, 2 is address, 3 is data.
- Status/config: bit 0 busy (read only), bit 1 read error (write 1 to clear), bit 2 format select (0 = single-frame format, 1 = address-phase format), bits 16 and up the MDC divider.
- Control: bits [4:0] device field, bits [9:5] port address, bit 15 read command (write 1 to start a read, reads back 0).
- Address: bits [15:0] register address.
- Data: bits [15:0] data value, bit 31 data busy.

Top module: `mdio_master`

## Requirements
- R1: After reset the status register, the control register, the address register and the data register all read 0. `mdc` and `mdio_oe` are 0.
- R2: When format select is 0, a write to the data register sends a frame with 32 ones, start 01, opcode 01, control bits [9:5], control bits [4:0], turnaround 10 and the written bits [15:0]. All 64 bits are driven, most significant first.
- R3: When format select is 1, a write to the address register sends an address frame: start 00, opcode 00, port, device field, turnaround 10 and the 16-bit address. When format select is 0, a write to the address register only stores the value and sends no frame.
- R4: A control write with bit 15 set starts a read frame. It uses the port and device field from that same write. The start and opcode are 01 10 when format select is 0, and 00 11 when it is 1. `mdio_oe` is 1 for the first 46 bits and 0 for the last 18. When format select is 1, a data write sends start 00 and opcode 01.
- R5: When a read completes, data register bits [15:0] hold the 16 bits sampled on the last 16 rising MDC edges, the first sampled bit in bit 15.
- R6: MDC is low whenever no frame is in progress. Each MDC phase lasts the divider value in system clocks. `mdio_o` never changes on a rising MDC edge.
- R7: Status bit 0 is 1 from the launching write until the frame ends. Data bit 31 is 1 during read and write frames and 0 during address frames.
- R8: If `mdio_i` is high when the second turnaround bit of a read is sampled, status bit 1 is set. The bit stays set until software writes 1 to status bit 1. If the set and the clear happen in the same cycle, the set wins.
- R9: A divider of zero holds MDC low and freezes a pending frame with busy still set. Writing a nonzero divider lets the frame run to completion.
- R10: While busy, writes to the control, address and data registers are ignored. They change no register and start no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the selected register (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Value driven on the data line |
| mdio_oe | output | 1 | Drive enable for the data line |
| mdio_i | input | 1 | Sampled data line |

## Verification
A software clear of the read-error bit can land in the same system cycle as the hardware set from the second turnaround bit. The bench provokes this by clearing the flag first and then starting a read with no PHY responding. It places the status write exactly on the clock edge where the turnaround sample is taken, which is 95 divider periods after the launching write. The flag must read 1 after the frame, and a clear that arrives during a read at any other time must leave it at 0.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 32;
  localparam int DRV_LEN   = PRE_LEN + 14;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(DRV_LEN);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(DRV_LEN + 1);
  localparam logic [1:0] SEL_STAT = 2'd0, SEL_CTL = 2'd1, SEL_ADDR = 2'd2, SEL_DATA = 2'd3;

  logic             enc, rderr, busy, dbusy, is_rd;
  logic [DIV_W-1:0] div, cnt;
  logic [4:0]       pa, da;
  logic [15:0]      addr, dat, rdsh;
  logic [IDX_W-1:0] idx;
  logic [FRAME_LEN-1:0] sh;

  wire acc   = reg_wr && !busy;
  wire go_wr = acc && reg_sel == SEL_DATA;
  wire go_rd = acc && reg_sel == SEL_CTL && reg_wdata[15];
  wire go_ad = acc && reg_sel == SEL_ADDR && enc;
  wire launch = go_wr || go_rd || go_ad;

  wire [4:0]  f_pa = go_rd ? reg_wdata[9:5] : pa;
  wire [4:0]  f_da = go_rd ? reg_wdata[4:0] : da;
  wire [1:0]  f_st = enc ? 2'b00 : 2'b01;
  wire [1:0]  f_op = go_ad ? 2'b00 : go_wr ? 2'b01 : (enc ? 2'b11 : 2'b10);
  wire [15:0] f_dt = go_rd ? 16'hFFFF : reg_wdata[15:0];
  wire [FRAME_LEN-1:0] frame = {{PRE_LEN{1'b1}}, f_st, f_op, f_pa, f_da, 2'b10, f_dt};

  wire tick    = busy && (div != '0) && (cnt >= div - DIV_W'(1));
  wire rising  = tick && !mdc;
  wire falling = tick && mdc;
  wire last    = idx == LAST_IDX;
  wire err_clr = reg_wr && reg_sel == SEL_STAT && reg_wdata[1];
  wire err_set = rising && is_rd && idx == TA2_IDX && mdio_i;

  assign mdio_o  = sh[FRAME_LEN-1];
  assign mdio_oe = busy && !(is_rd && idx >= REL_IDX);

  always_comb begin
    case (reg_sel)
      SEL_STAT: reg_rdata = {{(16-DIV_W){1'b0}}, div, 13'b0, enc, rderr, busy};
      SEL_CTL:  reg_rdata = {22'b0, pa, da};
      SEL_ADDR: reg_rdata = {16'b0, addr};
      default:  reg_rdata = {dbusy, 15'b0, dat};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enc <= 1'b0; rderr <= 1'b0; div <= '0;
      pa <= '0; da <= '0; addr <= '0; dat <= '0;
    end else begin
      rderr <= err_set || (rderr && !err_clr);
      if (reg_wr && reg_sel == SEL_STAT) begin
        enc <= reg_wdata[2];
        div <= reg_wdata[16 +: DIV_W];
      end
      if (acc && reg_sel == SEL_CTL) begin
        pa <= reg_wdata[9:5];
        da <= reg_wdata[4:0];
      end
      if (acc && reg_sel == SEL_ADDR) addr <= reg_wdata[15:0];
      if (go_wr) dat <= reg_wdata[15:0];
      else if (falling && last && is_rd) dat <= rdsh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; dbusy <= 1'b0; is_rd <= 1'b0; mdc <= 1'b0;
      cnt <= '0; idx <= '0; sh <= '0; rdsh <= '0;
    end else if (launch) begin
      busy <= 1'b1; dbusy <= !go_ad; is_rd <= go_rd; mdc <= 1'b0;
      cnt <= '0; idx <= '0; sh <= frame;
    end else if (busy) begin
      if (tick) begin
        cnt <= '0;
        if (!mdc) begin
          mdc <= 1'b1;
          if (is_rd && idx > TA2_IDX) rdsh <= {rdsh[14:0], mdio_i};
        end else begin
          mdc <= 1'b0;
          if (last) begin
            busy <= 1'b0; dbusy <= 1'b0;
          end else begin
            idx <= idx + IDX_W'(1);
            sh  <= {sh[FRAME_LEN-2:0], 1'b0};
          end
        end
      end else if (div != '0) begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  a_r6_idle_low: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mdc);
  a_r6_mdo_hold: assert property (@(posedge clk) disable iff (!rst_n) $rose(mdc) |-> $stable(mdio_o));
  a_r7_dbusy_in_busy: assert property (@(posedge clk) disable iff (!rst_n) dbusy |-> busy);
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n) rderr && !err_clr |=> rderr);
  a_r9_div_zero_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    busy && div == '0 |=> $stable(mdc) && $stable(idx));
  a_r10_busy_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !is_rd && reg_wr && reg_sel == SEL_DATA |=> $stable(dat));
endmodule

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int CLK_NS = 10;
  localparam int DIVV = 2;

  logic clk = 0, rst_n = 0;
  logic [1:0] reg_sel = 0;
  logic reg_wr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0, fails = 0;
  int cyc = 0, rise_n = 0, base = 0, last_rise = 0, period = 0;
  logic [63:0] cap = 0, oecap = 0;
  logic [15:0] resp = 0;
  logic phy_on = 1;

  mdio_master uut (.clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  int rel;
  assign rel = rise_n - base;
  assign mdio_i = !phy_on ? 1'b1 :
                  (rel == 47) ? 1'b0 :
                  (rel >= 48 && rel < 64) ? resp[63 - rel] : 1'b1;

  always @(posedge mdc) begin
    cap <= {cap[62:0], mdio_o};
    oecap <= {oecap[62:0], mdio_oe};
    rise_n <= rise_n + 1;
    period <= cyc - last_rise;
    last_rise <= cyc;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_sel = s; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rdreg(input logic [1:0] s, output logic [31:0] v);
    reg_sel = s; #1; v = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 40000; i++) begin
      rdreg(2'd0, v);
      if (!v[0]) return;
      @(negedge clk);
    end
  endtask

  function automatic logic [63:0] fr(input logic e, input logic [1:0] op,
                                     input logic [4:0] p, input logic [4:0] d, input logic [15:0] x);
    return {32'hFFFF_FFFF, e ? 2'b00 : 2'b01, op, p, d, 2'b10, x};
  endfunction

  localparam logic [63:0] OE_WR = {64{1'b1}};
  localparam logic [63:0] OE_RD = {{46{1'b1}}, 18'b0};

  task automatic run(input logic [1:0] s, input logic [31:0] d, input logic [63:0] ef,
                     input logic [63:0] eo, input logic edb, input string tag);
    logic [31:0] v;
    base = rise_n;
    wr(s, d);
    rdreg(2'd0, v);
    chk(v[0] == 1'b1, {tag, " R7 busy"}, v[0], 1);
    rdreg(2'd3, v);
    chk(v[31] == edb, {tag, " R7 data busy"}, v[31], edb);
    wait_idle();
    chk(rise_n - base == 64, {tag, " bit count"}, rise_n - base, 64);
    chk(oecap == eo, {tag, " R4 oe pattern"}, oecap, eo);
    chk((cap & eo) == (ef & eo), {tag, " frame"}, cap & eo, ef & eo);
    chk(mdc == 1'b0, {tag, " R6 idle low"}, mdc, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [4:0] p, d;
    logic [15:0] x;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < 4; s++) begin
      rdreg(s[1:0], v);
      chk(v == 0, "R1 reset register", v, 0);
    end
    chk(mdc == 0 && mdio_oe == 0, "R1 reset pins", {mdc, mdio_oe}, 0);

    wr(2'd0, DIVV << 16);
    for (int i = 0; i < 32; i++) begin
      p = i[4:0]; d = 5'(31 - i); x = 16'(i * 16'h0801) ^ 16'hA5C3;
      wr(2'd1, {22'b0, p, d});
      run(2'd3, {16'b0, x}, fr(0, 2'b01, p, d, x), OE_WR, 1, "R2 c22 write");
      rdreg(2'd3, v);
      chk(v[15:0] == x, "R2 data readback", v[15:0], x);
    end

    wr(2'd0, 32'h4 | (DIVV << 16));
    wr(2'd1, {22'b0, 5'd5, 5'd3});
    run(2'd2, 32'h1234, fr(1, 2'b00, 5'd5, 5'd3, 16'h1234), OE_WR, 0, "R3 c45 address");
    run(2'd3, 32'hBEEF, fr(1, 2'b01, 5'd5, 5'd3, 16'hBEEF), OE_WR, 1, "R4 c45 write");

    for (int m = 0; m < 2; m++) begin
      wr(2'd0, (m == 1 ? 32'h4 : 32'h0) | (DIVV << 16));
      for (int k = 0; k < 8; k++) begin
        p = 5'(k * 3 + m); d = 5'(k * 7 + 1); resp = 16'(16'h1357 * (k + 1)) ^ 16'(m * 16'hF00F);
        run(2'd1, {16'b0, 1'b1, 5'b0, p, d}, fr(m[0], m == 1 ? 2'b11 : 2'b10, p, d, 16'h0), OE_RD, 1,
            "R4 read");
        rdreg(2'd3, v);
        chk(v[15:0] == resp, "R5 read value", v[15:0], resp);
        rdreg(2'd0, v);
        chk(v[1] == 0, "R8 no error", v[1], 0);
      end
    end

    wr(2'd0, DIVV << 16);
    wr(2'd2, 32'h00AB);
    repeat (10) @(negedge clk);
    rdreg(2'd0, v);
    chk(v[0] == 0 && mdc == 0, "R3 c22 address write no frame", {v[0], mdc}, 0);
    rdreg(2'd2, v);
    chk(v == 32'h00AB, "R3 address stored", v, 32'h00AB);

    phy_on = 0;
    run(2'd1, 32'h8000 | (2 << 5) | 4, fr(0, 2'b10, 5'd2, 5'd4, 0), OE_RD, 1, "R8 absent read");
    rdreg(2'd0, v);
    chk(v[1] == 1, "R8 error set", v[1], 1);
    rdreg(2'd3, v);
    chk(v[15:0] == 16'hFFFF, "R8 ones read", v[15:0], 16'hFFFF);
    phy_on = 1; resp = 16'h0F0F;
    run(2'd1, 32'h8000 | (2 << 5) | 4, fr(0, 2'b10, 5'd2, 5'd4, 0), OE_RD, 1, "R8 good read");
    rdreg(2'd0, v);
    chk(v[1] == 1, "R8 sticky", v[1], 1);
    base = rise_n;
    wr(2'd1, 32'h8000 | (2 << 5) | 4);
    repeat (40) @(negedge clk);
    wr(2'd0, 32'h2 | (DIVV << 16));
    wait_idle();
    rdreg(2'd0, v);
    chk(v[1] == 0, "R8 clear mid read", v[1], 1'b0);

    phy_on = 0;
    base = rise_n;
    wr(2'd1, 32'h8000 | (1 << 5) | 1);
    repeat (95 * DIVV - 1) @(negedge clk);
    wr(2'd0, 32'h2 | (DIVV << 16));
    wait_idle();
    rdreg(2'd0, v);
    chk(v[1] == 1, "R8 set wins over clear", v[1], 1);
    phy_on = 1;

    wr(2'd1, {22'b0, 5'd9, 5'd10});
    base = rise_n;
    wr(2'd3, 32'h1111);
    repeat (20) @(negedge clk);
    wr(2'd3, 32'h2222);
    wr(2'd1, {22'b0, 5'd1, 5'd2});
    wr(2'd2, 32'h3333);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(rise_n - base == 64, "R10 no extra frame", rise_n - base, 64);
    rdreg(2'd3, v);
    chk(v[15:0] == 16'h1111, "R10 data held", v[15:0], 16'h1111);
    rdreg(2'd1, v);
    chk(v[9:0] == {5'd9, 5'd10}, "R10 control held", v[9:0], {5'd9, 5'd10});
    rdreg(2'd2, v);
    chk(v == 32'h00AB, "R10 address held", v, 32'h00AB);

    wr(2'd0, 32'h0);
    base = rise_n;
    wr(2'd3, 32'h5A5A);
    repeat (100) @(negedge clk);
    rdreg(2'd0, v);
    chk(v[0] == 1 && mdc == 0 && rise_n == base, "R9 frozen", {v[0], mdc}, 2'b10);
    wr(2'd0, DIVV << 16);
    wait_idle();
    chk(rise_n - base == 64 && cap == fr(0, 2'b01, 5'd9, 5'd10, 16'h5A5A), "R9 resumed frame",
        cap, fr(0, 2'b01, 5'd9, 5'd10, 16'h5A5A));

    wr(2'd0, 3 << 16);
    run(2'd3, 32'hC3C3, fr(0, 2'b01, 5'd9, 5'd10, 16'hC3C3), OE_WR, 1, "R6 divider 3");
    chk(period == 6, "R6 mdc period", period, 6);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule